// File: doc/BRIEF.md
# Preconditioned-Operand 16-bit ALU

This block is a purely combinational arithmetic logic unit. It accepts two 16-bit operands, A and B, and six independent control bits, and it produces a 16-bit result and two status flags. The block has no opcode decoder. Each operand can first be cleared to zero and can then be bitwise inverted. A single core function, either the two's-complement sum or the bitwise AND, is applied to the two conditioned operands. The core output can then be inverted. These few orthogonal steps combine into a fixed set of eighteen useful functions, such as constants, negation, increment, decrement, difference and OR.

The flags describe the final result. One flag is set when every result bit is clear. The other flag copies the sign bit. The block holds no state and has no clock. A caller drives the operands and the control bits and reads the result in the same cycle, so this block needs no valid/ready flow control. Neither a carry-out nor an overflow indication is produced.

The control word below is written MSB first, in the order {clr_a, neg_a, clr_b, neg_b, use_sum, neg_res}. The requirements use this order.

Top module: `alu16_pre`

## Requirements
- R1: Operand A is conditioned in two steps. First, when clr_a=1 the operand is replaced by 0x0000. Then, when neg_a=1 the value from the first step is bitwise inverted. For example, clr_a=1 and neg_a=1 give 0xFFFF.
- R2: Operand B is conditioned by clr_b and neg_b in the same way and in the same order.
- R3: When use_sum=1, the core output is the 16-bit sum of the conditioned operands modulo 2^16. The carry out of bit 15 is dropped, so 0xFFFF + 0x0001 gives 0x0000.
- R4: When use_sum=0, the core output is the bitwise AND of the conditioned operands.
- R5: When neg_res=1, the core output is bitwise inverted before it drives res. Otherwise it drives res unchanged.
- R6: is_zero is 1 exactly when all 16 bits of res are 0. A 1 in any single bit position clears is_zero.
- R7: is_neg always equals res[15].
- R8: The eighteen control words give these functions:
  - 101010 → 0
  - 111111 → 1
  - 111010 → -1
  - 001100 → A
  - 110000 → B
  - 001101 → ~A
  - 110001 → ~B
  - 001111 → -A
  - 110011 → -B
  - 011111 → A+1
  - 110111 → B+1
  - 001110 → A-1
  - 110010 → B-1
  - 000010 → A+B
  - 010011 → A-B
  - 000111 → B-A
  - 000000 → A&B
  - 010101 → A|B
- R9: A=0x0011, B=0x0003 with control word 110111 gives res=0x0004, is_zero=0 and is_neg=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| clr_a | input | 1 | Clear operand A before the inversion step |
| neg_a | input | 1 | Invert the conditioned operand A |
| clr_b | input | 1 | Clear operand B before the inversion step |
| neg_b | input | 1 | Invert the conditioned operand B |
| use_sum | input | 1 | 1 selects the sum, 0 selects the AND |
| neg_res | input | 1 | Invert the core output |
| res | output | 16 | Final result |
| is_zero | output | 1 | Set when res is 0x0000 |
| is_neg | output | 1 | Copy of res[15] |

## Verification
The bench walks a single 1 through every result bit. A zero flag built from one bit, or from a bitwise OR of two words, would then report zero for most of these results. It drives each clear and invert bit for both operands in both orders of effect. A design that inverts before clearing would then give 0x0000 where 0xFFFF is expected. All eighteen control words are applied across several operand pairs, including the y+1 case with 0x0011 and 0x0003, where a stray carry or a wrong AND path shows up as an extra set bit. Sums that wrap at 0xFFFF and results with the sign bit set check that the carry is dropped and that the negative flag follows bit 15.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int unsigned DATA_W = 16;

  // Per-operand conditioning controls.
  typedef struct packed {
    logic clear;
    logic invert;
  } cond_ctl_t;
endpackage

// File: rtl/alu16_cond.sv
// Operand conditioner: clear, then invert.
module alu16_cond #(
  parameter int unsigned W = alu16_pkg::DATA_W
) (
  input  logic [W-1:0]          din,
  input  alu16_pkg::cond_ctl_t  ctl,
  output logic [W-1:0]          dout
);
  logic [W-1:0] cleared;

  assign cleared = ctl.clear ? '0 : din;
  assign dout    = ctl.invert ? ~cleared : cleared;
endmodule

// File: rtl/alu16_core.sv
// Core function: ripple sum or bitwise AND, followed by an optional inversion.
module alu16_core #(
  parameter int unsigned W = alu16_pkg::DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         use_sum,
  input  logic         neg_res,
  output logic [W-1:0] y
);
  logic [W-1:0] sum;
  logic [W-1:0] cin;
  logic [W-1:0] core;

  assign cin[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = a[i] ^ b[i] ^ cin[i];
    if (i < W - 1) begin : g_carry
      assign cin[i+1] = (a[i] & b[i]) | (cin[i] & (a[i] ^ b[i]));
    end
  end

  assign core = use_sum ? sum : (a & b);
  assign y    = neg_res ? ~core : core;
endmodule

// File: rtl/alu16_zdet.sv
// Balanced OR-reduction tree over the full word; output high when all bits are zero.
module alu16_zdet #(
  parameter int unsigned W = alu16_pkg::DATA_W
) (
  input  logic [W-1:0] v,
  output logic         all_zero
);
  localparam int unsigned LV = (W < 2) ? 1 : $clog2(W);
  localparam int unsigned P  = 1 << LV;

  logic [P-1:0] pad;
  assign pad = P'(v);

  for (genvar k = 0; k < LV; k++) begin : g_lvl
    localparam int unsigned N = P >> (k + 1);
    logic [N-1:0] o;
    for (genvar j = 0; j < N; j++) begin : g_node
      if (k == 0) begin : g_leaf
        assign o[j] = pad[2*j] | pad[2*j+1];
      end else begin : g_inner
        assign o[j] = g_lvl[k-1].o[2*j] | g_lvl[k-1].o[2*j+1];
      end
    end
  end

  assign all_zero = ~g_lvl[LV-1].o[0];
endmodule

// File: rtl/alu16_pre.sv
module alu16_pre #(
  parameter int unsigned W = alu16_pkg::DATA_W
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         clr_a,
  input  logic         neg_a,
  input  logic         clr_b,
  input  logic         neg_b,
  input  logic         use_sum,
  input  logic         neg_res,
  output logic [W-1:0] res,
  output logic         is_zero,
  output logic         is_neg
);
  alu16_pkg::cond_ctl_t ctl_a, ctl_b;
  logic [W-1:0] ca, cb;

  assign ctl_a = '{clear: clr_a, invert: neg_a};
  assign ctl_b = '{clear: clr_b, invert: neg_b};

  alu16_cond #(.W(W)) u_cond_a (.din(op_a), .ctl(ctl_a), .dout(ca));
  alu16_cond #(.W(W)) u_cond_b (.din(op_b), .ctl(ctl_b), .dout(cb));

  alu16_core #(.W(W)) u_core (
    .a(ca), .b(cb), .use_sum(use_sum), .neg_res(neg_res), .y(res)
  );

  alu16_zdet #(.W(W)) u_zdet (.v(res), .all_zero(is_zero));

  assign is_neg = res[W-1];
endmodule

// File: rtl/alu16_pre_chk.sv
module alu16_pre_chk #(
  parameter int unsigned W = alu16_pkg::DATA_W
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         clr_a,
  input logic         neg_a,
  input logic         clr_b,
  input logic         neg_b,
  input logic         use_sum,
  input logic         neg_res,
  input logic [W-1:0] res,
  input logic         is_zero,
  input logic         is_neg
);
  logic [5:0] cw;
  assign cw = {clr_a, neg_a, clr_b, neg_b, use_sum, neg_res};

  always_comb begin
    assert_zero_flag_R6: assert (is_zero == (res == '0))
      else $error("zero flag disagrees with result");
    assert_sign_flag_R7: assert (is_neg == res[W-1])
      else $error("sign flag disagrees with result");
    if (cw == 6'b000010) begin
      assert_plain_sum_R3: assert (res == W'(op_a + op_b))
        else $error("plain sum wrong");
    end
    if (cw == 6'b000000) begin
      assert_plain_and_R4: assert (res == (op_a & op_b))
        else $error("plain AND wrong");
    end
    if (cw == 6'b110000) begin
      assert_clear_invert_a_R1: assert (res == op_b)
        else $error("cleared and inverted A should pass B");
    end
    if (cw == 6'b000001) begin
      assert_out_invert_R5: assert (res == ~(op_a & op_b))
        else $error("inverted AND wrong");
    end
  end
endmodule

bind alu16_pre alu16_pre_chk #(.W(W)) u_chk (.*);

// File: tb/tb_alu16_pre.sv
module tb_alu16_pre;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] a, b, res;
  logic [5:0]  cw;
  logic        is_zero, is_neg;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  alu16_pre dut (
    .op_a(a), .op_b(b),
    .clr_a(cw[5]), .neg_a(cw[4]), .clr_b(cw[3]), .neg_b(cw[2]),
    .use_sum(cw[1]), .neg_res(cw[0]),
    .res(res), .is_zero(is_zero), .is_neg(is_neg)
  );

  localparam logic [5:0] OPS [18] = '{
    6'b101010, 6'b111111, 6'b111010, 6'b001100, 6'b110000, 6'b001101,
    6'b110001, 6'b001111, 6'b110011, 6'b011111, 6'b110111, 6'b001110,
    6'b110010, 6'b000010, 6'b010011, 6'b000111, 6'b000000, 6'b010101};

  function automatic logic [15:0] want_op(int k, logic [15:0] x, logic [15:0] y);
    case (k)
      0: return 16'h0000;   1: return 16'h0001;   2: return 16'hFFFF;
      3: return x;          4: return y;          5: return ~x;
      6: return ~y;         7: return 16'(-x);    8: return 16'(-y);
      9: return 16'(x + 1); 10: return 16'(y + 1); 11: return 16'(x - 1);
      12: return 16'(y - 1); 13: return 16'(x + y); 14: return 16'(x - y);
      15: return 16'(y - x); 16: return x & y;    default: return x | y;
    endcase
  endfunction

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic [5:0] c);
    @(posedge clk);
    a = x; b = y; cw = c;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] want);
    n_chk++;
    if (res !== want || is_zero !== (want == 16'h0) || is_neg !== want[15]) begin
      n_fail++;
      $display("FAIL %s: cw=%b a=%h b=%h res=%h z=%b n=%b expected res=%h z=%b n=%b",
               req, cw, a, b, res, is_zero, is_neg, want, want == 16'h0, want[15]);
    end
  endtask

  task automatic t_idle();
    apply(16'h0, 16'h0, 6'b000000);
    check("R4 idle zero inputs", 16'h0000);
  endtask

  task automatic t_example();
    apply(16'h0011, 16'h0003, 6'b110111);
    check("R9 y+1 example", 16'h0004);
  endtask

  task automatic t_table();
    logic [15:0] xs [5] = '{16'h0011, 16'h0000, 16'hFFFF, 16'h8000, 16'h1234};
    logic [15:0] ys [5] = '{16'h0003, 16'h0000, 16'h0001, 16'h7FFF, 16'hA5C3};
    for (int p = 0; p < 5; p++)
      for (int k = 0; k < 18; k++) begin
        apply(xs[p], ys[p], OPS[k]);
        check("R8 function table", want_op(k, xs[p], ys[p]));
      end
  endtask

  task automatic t_cond_order();
    // clear then invert yields all ones; AND with 0xFFFF on the other side passes it.
    apply(16'h5A5A, 16'hFFFF, 6'b110000);
    check("R1 clear-then-invert A", 16'hFFFF);
    apply(16'h5A5A, 16'hFFFF, 6'b010000);
    check("R1 invert only A", 16'hA5A5);
    apply(16'h5A5A, 16'hFFFF, 6'b100000);
    check("R1 clear only A", 16'h0000);
    apply(16'hFFFF, 16'h3C3C, 6'b001100);
    check("R2 clear-then-invert B", 16'hFFFF);
    apply(16'hFFFF, 16'h3C3C, 6'b000100);
    check("R2 invert only B", 16'hC3C3);
    apply(16'hFFFF, 16'h3C3C, 6'b001000);
    check("R2 clear only B", 16'h0000);
  endtask

  task automatic t_sum_wrap();
    apply(16'hFFFF, 16'h0001, 6'b000010);
    check("R3 carry dropped", 16'h0000);
    apply(16'h7FFF, 16'h0001, 6'b000010);
    check("R3 sum into sign bit", 16'h8000);
    apply(16'hF0F0, 16'h3333, 6'b000000);
    check("R4 bitwise AND", 16'h3030);
    apply(16'hF0F0, 16'h3333, 6'b000001);
    check("R5 inverted AND", 16'hCFCF);
    apply(16'h1234, 16'h1111, 6'b000011);
    check("R5 inverted sum", 16'hDCBA);
  endtask

  task automatic t_walk_one();
    for (int i = 0; i < 16; i++) begin
      apply(16'(1 << i), 16'h0, 6'b001100);
      check("R6 single set bit clears zero flag, R7 sign", 16'(1 << i));
    end
  endtask

  initial begin
    a = '0; b = '0; cw = '0;
    t_idle();
    t_example();
    t_cond_order();
    t_sum_wrap();
    t_walk_one();
    t_table();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule